// File: doc/BRIEF.md
# Staged Split-Width Event Counter Bank

This block holds a small bank of physical event counters that software reaches through a 64-bit register bus. Each physical counter works either as one 32-bit counter or as two independent 16-bit halves. A split counter therefore gives two logical counters, and the bank as a whole offers up to twice as many logical counters as it has physical ones. Per-logical-counter event pulses drive the counting while a global enable bit is set.

Software never writes a live counter directly. A counter write is parked in a holding latch for that physical counter. Every parked value is copied into its live counter when software writes the control word with the enable bit set, and this happens even when the bank is already enabled. A counter that wraps past its all-ones value in its current width raises a sticky overflow bit. Reading the status register returns these bits and clears them. Writing the status register sets the mask that decides which bits drive the interrupt line.

Top module: `perfmon_bank`

## Requirements
- R1: After reset every live counter is zero, no latch is pending, the control word is zero (disabled, all counters 32-bit), status and mask are zero, and `irq` is low.
- R2: Register index map on `bus_addr`: 0–3 are logical counters 0–3, 4–7 are logical counters 4–7, 8 is control and 9 is status. The 32-bit register value travels on bus bits 63:32. `bus_wdata[31:0]` is ignored, `bus_rdata[31:0]` reads as zero, `bus_rdata` is zero when no read is in progress, and indices 10–15 read as zero.
- R3: In the control word, bit 31 is the global enable and bit p (0–3) selects split mode for physical counter p (1 = two 16-bit halves). The control word reads back as written in those bits.
- R4: While enabled, a 32-bit physical counter p increments by one on each clock where `event_pulse[p]` is high, and `event_pulse[p+4]` has no effect on it. While disabled, counters hold their values.
- R5: In split mode the upper half of counter p counts `event_pulse[p]` and the lower half counts `event_pulse[p+4]`, with no carry between them. Logical p reads the upper half and logical p+4 reads the lower half, each zero-extended in bits 15:0 of the register value.
- R6: When physical counter p is in 32-bit mode, logical counter p+4 reads as zero and writes to it are ignored.
- R7: A counter write changes only the holding latch. The live value read back is unchanged until a commit.
- R8: A control write with bit 31 set copies every pending latch into its live counter and clears all pending flags, also when already enabled. Counters with no pending value are left alone. A control write with bit 31 clear commits nothing.
- R9: A write to a 16-bit logical counter replaces only its own half of the latch. The other half comes from the pending latch if one exists, and from the live counter otherwise.
- R10: When a commit and an event for the same counter fall in the same cycle, the committed value is loaded and the event is dropped.
- R11: A wrap from all ones to zero sets a status bit: bit p for a 32-bit counter p or the upper half of a split counter p, and bit p+4 for the lower half of split counter p.
- R12: A status read returns the sticky bits in bits 7:0 and clears them in the same access. A status write loads the interrupt mask from bits 7:0, with zero disabling all. `irq` is high while any status bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | 64 | Write data, value in bits 63:32 |
| bus_rdata | output | 64 | Read data, combinational in the access cycle, value in bits 63:32 |
| event_pulse | input | 2*NPHYS | Per-logical-counter increment pulses |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The assertions assume that a bus access lasts exactly one cycle and that `NPHYS` is a power of two, so that the low index bits select the physical counter. They also assume that the enable bit in a control write is a plain level, with no other side effect. The bench drives every access and every event pulse on the falling edge and holds it for whole cycles, so each access is seen at exactly one rising edge. It only commits through control writes, and it only raises events whose effect on a counter it has already worked out.

// File: rtl/perfmon_bank.sv
module perfmon_bank #(
  parameter int NPHYS  = 4,
  parameter int ADDR_W = 4,
  parameter int EN_BIT = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [63:0]          bus_wdata,
  output logic [63:0]          bus_rdata,
  input  logic [2*NPHYS-1:0]   event_pulse,
  output logic                 irq
);
  localparam int NLOG = 2 * NPHYS;
  localparam int PW   = $clog2(NPHYS);
  localparam logic [ADDR_W-1:0] CTL_ADDR  = ADDR_W'(NLOG);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NLOG + 1);
  localparam logic [ADDR_W-1:0] LO_BASE   = ADDR_W'(NPHYS);

  logic [NPHYS-1:0][31:0] ctr, latch;
  logic [NPHYS-1:0]       pend, split, inc_hi, inc_lo;
  logic                   enable;
  logic [NLOG-1:0]        status, mask, ov;
  logic [31:0]            wval, rd_val, base;
  logic                   wr_en, rd_en, commit, upper_sel, lower_sel, unused_ok;
  logic [PW-1:0]          sel_p;

  assign wval      = bus_wdata[63:32];
  assign unused_ok = ^bus_wdata[31:0];
  assign wr_en     = bus_sel & bus_wr;
  assign rd_en     = bus_sel & ~bus_wr;
  assign sel_p     = bus_addr[PW-1:0];
  assign upper_sel = bus_addr < LO_BASE;
  assign lower_sel = !upper_sel && bus_addr < CTL_ADDR;
  assign commit    = wr_en && bus_addr == CTL_ADDR && wval[EN_BIT];
  assign base      = pend[sel_p] ? latch[sel_p] : ctr[sel_p];
  assign irq       = |(status & mask);

  always_comb begin
    for (int p = 0; p < NPHYS; p++) begin
      inc_hi[p] = enable & event_pulse[p];
      inc_lo[p] = enable & split[p] & event_pulse[p+NPHYS];
      ov[p] = inc_hi[p] && !(commit && pend[p]) &&
              (split[p] ? &ctr[p][31:16] : &ctr[p]);
      ov[p+NPHYS] = inc_lo[p] && !(commit && pend[p]) && &ctr[p][15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr   <= '0;
      latch <= '0;
      pend  <= '0;
    end else begin
      for (int p = 0; p < NPHYS; p++) begin
        if (commit && pend[p]) begin
          ctr[p] <= latch[p];
        end else if (split[p]) begin
          ctr[p][31:16] <= ctr[p][31:16] + 16'(inc_hi[p]);
          ctr[p][15:0]  <= ctr[p][15:0] + 16'(inc_lo[p]);
        end else begin
          ctr[p] <= ctr[p] + 32'(inc_hi[p]);
        end
      end
      if (commit) begin
        pend <= '0;
      end else if (wr_en && upper_sel) begin
        latch[sel_p] <= split[sel_p] ? {wval[15:0], base[15:0]} : wval;
        pend[sel_p]  <= 1'b1;
      end else if (wr_en && lower_sel && split[sel_p]) begin
        latch[sel_p] <= {base[31:16], wval[15:0]};
        pend[sel_p]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      split  <= '0;
      status <= '0;
      mask   <= '0;
    end else begin
      if (wr_en && bus_addr == CTL_ADDR) begin
        enable <= wval[EN_BIT];
        split  <= wval[NPHYS-1:0];
      end
      if (wr_en && bus_addr == STAT_ADDR) mask <= wval[NLOG-1:0];
      status <= ((rd_en && bus_addr == STAT_ADDR) ? '0 : status) | ov;
    end
  end

  always_comb begin
    rd_val = '0;
    if (upper_sel)
      rd_val = split[sel_p] ? {16'h0, ctr[sel_p][31:16]} : ctr[sel_p];
    else if (lower_sel)
      rd_val = split[sel_p] ? {16'h0, ctr[sel_p][15:0]} : '0;
    else if (bus_addr == CTL_ADDR) begin
      rd_val[NPHYS-1:0] = split;
      rd_val[EN_BIT]    = enable;
    end else if (bus_addr == STAT_ADDR)
      rd_val[NLOG-1:0] = status;
    bus_rdata = rd_en ? {rd_val, 32'h0} : '0;
  end
endmodule

// File: rtl/perfmon_bank_chk.sv
module perfmon_bank_chk #(
  parameter int NPHYS  = 4,
  parameter int ADDR_W = 4,
  parameter int EN_BIT = 31
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   en_bit_in,
  input logic                   irq,
  input logic [NPHYS-1:0][31:0] ctr,
  input logic [NPHYS-1:0][31:0] latch,
  input logic [NPHYS-1:0]       pend,
  input logic                   enable,
  input logic [2*NPHYS-1:0]     status,
  input logic [2*NPHYS-1:0]     mask,
  input logic [2*NPHYS-1:0]     ov
);
  localparam logic [ADDR_W-1:0] CTL_ADDR  = ADDR_W'(2 * NPHYS);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(2 * NPHYS + 1);

  logic commit_c, stat_rd_c;
  assign commit_c  = bus_sel && bus_wr && bus_addr == CTL_ADDR && en_bit_in;
  assign stat_rd_c = bus_sel && !bus_wr && bus_addr == STAT_ADDR;

  // R4 R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !commit_c) |=> $stable(ctr));

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_c |=> (pend == '0));

  // R12
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_c |=> ((status & $past(status) & ~$past(ov)) == '0));

  // R11
  ov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ov) |=> ((status & $past(ov)) == $past(ov)));

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  for (genvar p = 0; p < NPHYS; p++) begin : g_ctr
    // R8 R10
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_c && pend[p]) |=> (ctr[p] == $past(latch[p])));
  end
endmodule

bind perfmon_bank perfmon_bank_chk #(.NPHYS(NPHYS), .ADDR_W(ADDR_W), .EN_BIT(EN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .en_bit_in(bus_wdata[32+EN_BIT]), .irq(irq), .ctr(ctr), .latch(latch), .pend(pend),
  .enable(enable), .status(status), .mask(mask), .ov(ov)
);

// File: tb/perfmon_bank_tb.sv
module perfmon_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [7:0]  event_pulse = '0;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  perfmon_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .event_pulse(event_pulse), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v, input logic [31:0] junk = 32'h0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = {v, junk};
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [63:0] d;
    rd(a, d);
    chk(req, d[63:32], exp);
  endtask

  task automatic pulse(input logic [7:0] v, input int n);
    @(negedge clk);
    event_pulse = v;
    repeat (n) @(negedge clk);
    event_pulse = '0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 10; a++) rd_chk("R1 reset register", 4'(a), 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_bus;
    logic [63:0] d;
    chk("R2 rdata idle", bus_rdata[31:0] | bus_rdata[63:32], 32'h0);
    wr(4'd8, 32'h0000_0005, 32'hFFFF_FFFF);
    rd(4'd8, d);
    chk("R3 control readback", d[63:32], 32'h0000_0005);
    chk("R2 low word zero", d[31:0], 32'h0);
    rd_chk("R2 unmapped index", 4'd12, 32'h0);
    wr(4'd8, 32'h0);
    rd_chk("R3 control cleared", 4'd8, 32'h0);
  endtask

  task automatic t_stage;
    wr(4'd0, 32'd100);
    rd_chk("R7 staged write not live", 4'd0, 32'd0);
    wr(4'd8, 32'h0);
    rd_chk("R8 no commit without enable", 4'd0, 32'd0);
    wr(4'd8, 32'h8000_0000);
    rd_chk("R8 commit on enable", 4'd0, 32'd100);
    rd_chk("R8 non-pending untouched", 4'd1, 32'd0);
  endtask

  task automatic t_count;
    pulse(8'h11, 5);
    rd_chk("R4 32-bit count", 4'd0, 32'd105);
    rd_chk("R6 logical 4 reads zero in 32-bit", 4'd4, 32'd0);
    wr(4'd8, 32'h0);
    pulse(8'h01, 3);
    rd_chk("R4 hold while disabled", 4'd0, 32'd105);
  endtask

  task automatic t_split;
    wr(4'd8, 32'h0000_0001);
    rd_chk("R5 upper half view", 4'd0, 32'd0);
    rd_chk("R5 lower half view", 4'd4, 32'd105);
    wr(4'd8, 32'h8000_0001);
    pulse(8'h11, 2);
    pulse(8'h10, 2);
    rd_chk("R5 upper count", 4'd0, 32'd2);
    rd_chk("R5 lower count", 4'd4, 32'd109);
    wr(4'd4, 32'h0000_1234);
    wr(4'd0, 32'h0000_0055);
    rd_chk("R7 split staged upper", 4'd0, 32'd2);
    wr(4'd8, 32'h8000_0001);
    rd_chk("R8 R9 committed upper", 4'd0, 32'h55);
    rd_chk("R9 committed lower", 4'd4, 32'h1234);
    wr(4'd8, 32'h8000_0000);
    rd_chk("R9 merged full word", 4'd0, 32'h0055_1234);
    wr(4'd4, 32'h0000_7777);
    wr(4'd8, 32'h8000_0000);
    rd_chk("R6 write to logical 4 ignored", 4'd0, 32'h0055_1234);
  endtask

  task automatic t_overflow;
    wr(4'd2, 32'hFFFF_FFFE);
    wr(4'd8, 32'h8000_0000);
    pulse(8'h04, 1);
    rd_chk("R11 before wrap", 4'd2, 32'hFFFF_FFFF);
    pulse(8'h04, 1);
    rd_chk("R11 wrapped", 4'd2, 32'h0);
    chk("R12 irq masked off", {31'h0, irq}, 32'h0);
    wr(4'd9, 32'h0000_0004);
    #1 chk("R12 irq with mask", {31'h0, irq}, 32'h1);
    rd_chk("R11 R12 status bit 2", 4'd9, 32'h04);
    #1 chk("R12 irq after clear", {31'h0, irq}, 32'h0);
    rd_chk("R12 status cleared", 4'd9, 32'h0);
    wr(4'd8, 32'h8000_0008);
    wr(4'd7, 32'h0000_FFFF);
    wr(4'd3, 32'h0000_0001);
    wr(4'd8, 32'h8000_0008);
    pulse(8'h80, 1);
    rd_chk("R11 lower half wrapped", 4'd7, 32'h0);
    rd_chk("R5 no carry into upper", 4'd3, 32'h1);
    rd_chk("R11 status bit 7", 4'd9, 32'h80);
  endtask

  task automatic t_priority;
    wr(4'd8, 32'h8000_0000);
    wr(4'd1, 32'd500);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd8; bus_wdata = {32'h8000_0000, 32'h0};
    event_pulse = 8'h02;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; event_pulse = '0;
    rd_chk("R10 commit beats event", 4'd1, 32'd500);
    pulse(8'h02, 1);
    rd_chk("R10 counting resumes", 4'd1, 32'd501);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bus();
    t_stage();
    t_count();
    t_split();
    t_overflow();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule